// File: doc/BRIEF.md
# Chained Hash Page Table Walker

This block turns a virtual address into a physical address by looking it up in a hashed relocation table that lives in on-chip arrays. The upper bits of the virtual address are joined with an 8-bit address space identifier. That identifier comes from either a user or a supervisor register value, depending on the privilege of the request. The combined key is split into a table index and a tag. The walker starts at the indexed entry and follows next-entry links one probe per cycle. It stops when it finds an entry whose tag matches and whose protection allows the access.

A header bit on each entry marks the start of a collision chain. The first entry probed must carry it, and any later entry must not. Reaching a header entry again means the chain has wrapped, and the request ends with a bus error. A probe counter also forces a bus error so that a corrupted table cannot stall the block. A hit sets a usage bit for the table slot that matched. A bypass request returns the virtual address unchanged. A CPU-side port reads and writes table entries and usage bits.

Requests use a valid/ready handshake, and only one request is in flight at a time. Each result appears as a one-cycle response pulse.

Top module: `hash_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `reqReady` is 1 and `respValid` is 0.
- R2: The key is {identifier, reqAddr[31:10]}, where the identifier is `asiSuper` when `reqSuper`=1 and `asiUser` otherwise. With `splitSel`=0 the index is key[5:0] and the tag is key[29:6]. With `splitSel`=1 the index is key[8:3] and the tag is {key[29:9], key[2:0]}. Both are captured when the request is accepted.
- R3: A table entry is 56 bits. Bit 0 is the header. Bits 24:1 are the tag. Bits 30:25 are the next index. Bit 31 permits reads, bit 32 permits writes and bit 33 permits user access. Bits 55:34 are the relocation value.
- R4: A hit returns `respAddr` = {relocation, reqAddr[9:0]} with `respBusErr`=0. `respValid` is high for exactly one cycle.
- R5: An access is allowed only if the read bit (for reads) or the write bit (for writes) is set, and, for user requests, the user bit is also set. An entry that matches the tag but denies the access counts as a miss.
- R6: On a miss the walker moves to the entry's next index. Each probe takes one cycle, so a result found on probe N is valid N cycles after the accepting edge.
- R7: A first probe whose entry has its header bit clear ends in a bus error. A later probe that reaches an entry with its header bit set also ends in a bus error.
- R8: If MAX_PROBES (16384) probes finish without a hit or a header error, the request ends with a bus error.
- R9: A hit sets the usage bit of the matching index. A bus error or a bypass leaves all usage bits unchanged. `usageWe` writes `usageWrBit` at `tblAddr`, and `usageRdBit` shows the bit at `tblAddr`.
- R10: With `bypass`=1, the response comes one cycle after acceptance, with `respAddr`=`reqAddr` and no bus error.
- R11: `reqReady` is low while a walk is in progress. Requests offered during that time are ignored and produce no response.
- R12: `tblWe` writes `tblWrData` to the entry at `tblAddr`. `tblRdData` shows that entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle, request accepted |
| reqAddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access |
| reqSuper | input | 1 | 1 = supervisor privilege |
| bypass | input | 1 | Pass the address through untranslated |
| splitSel | input | 1 | Selects the index/tag split point |
| asiUser | input | 8 | Identifier used for user requests |
| asiSuper | input | 8 | Identifier used for supervisor requests |
| respValid | output | 1 | One-cycle response strobe |
| respBusErr | output | 1 | Response is a bus error |
| respAddr | output | 32 | Physical address |
| tblAddr | input | 6 | CPU port entry index |
| tblWe | input | 1 | CPU entry write |
| tblWrData | input | 56 | Entry write data |
| tblRdData | output | 56 | Entry read data |
| usageWe | input | 1 | CPU usage bit write |
| usageWrBit | input | 1 | Usage bit write value |
| usageRdBit | output | 1 | Usage bit at tblAddr |

## Verification
The address patterns include a hit on the first probe, hits on the second and third entry of a chain, and a chain that wraps back to its header. Reads and writes to the same chain separate the permission checks: the write skips a read-only entry. A supervisor request to the same address separates the two identifier registers. One address is tried under both split settings, and each setting lands on a different slot with a different relocation. A cyclic chain with no header shows that the probe cap fires at exactly the limit and not at a wrap. Requests offered while that walk runs show they are ignored.

// File: rtl/walker_pkg.sv
`timescale 1ns/1ps
package walker_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic advance;
    logic finishHit;
    logic finishErr;
    logic finishBypass;
    logic firstProbe;
  } walkStrobe_t;

endpackage

// File: rtl/walker_ctrl.sv
`timescale 1ns/1ps
module walker_ctrl
  import walker_pkg::*;
#(
  parameter int MAX_PROBES = 16384,
  localparam int CNT_W = $clog2(MAX_PROBES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        bypass,
  input  logic        probeHit,
  input  logic        probeRuleErr,
  output logic        reqReady,
  output walkStrobe_t strobe
);

  localparam logic [CNT_W-1:0] LAST_PROBE = CNT_W'(MAX_PROBES - 1);

  walkState_t       state;
  logic             firstProbe;
  logic [CNT_W-1:0] probeCnt;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.firstProbe = firstProbe;
    if (state == ST_IDLE) begin
      if (reqValid) begin
        if (bypass) strobe.finishBypass = 1'b1;
        else        strobe.loadReq      = 1'b1;
      end
    end else begin
      if (probeHit)                    strobe.finishHit = 1'b1;
      else if (probeRuleErr)           strobe.finishErr = 1'b1;
      else if (probeCnt == LAST_PROBE) strobe.finishErr = 1'b1;
      else                             strobe.advance   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      firstProbe <= 1'b0;
      probeCnt   <= '0;
    end else begin
      if (strobe.loadReq) begin
        state      <= ST_WALK;
        firstProbe <= 1'b1;
        probeCnt   <= '0;
      end else if (strobe.advance) begin
        firstProbe <= 1'b0;
        probeCnt   <= probeCnt + 1'b1;
      end else if (strobe.finishHit || strobe.finishErr) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/walker_dp.sv
`timescale 1ns/1ps
module walker_dp
  import walker_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int VPN_W     = 22,
  parameter int ASI_W     = 8,
  parameter int IDX_W     = 6,
  parameter int ALT_SHIFT = 3,
  localparam int OFF_W    = VA_W - VPN_W,
  localparam int KEY_W    = ASI_W + VPN_W,
  localparam int TAG_W    = KEY_W - IDX_W,
  localparam int ENT_W    = VPN_W + 3 + IDX_W + TAG_W + 1,
  localparam int DEPTH    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  walkStrobe_t      strobe,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic             reqWrite,
  input  logic             reqSuper,
  input  logic             splitSel,
  input  logic [ASI_W-1:0] asiUser,
  input  logic [ASI_W-1:0] asiSuper,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic             tblWe,
  input  logic [ENT_W-1:0] tblWrData,
  output logic [ENT_W-1:0] tblRdData,
  input  logic             usageWe,
  input  logic             usageWrBit,
  output logic             usageRdBit,
  output logic             probeHit,
  output logic             probeRuleErr,
  output logic             respValid,
  output logic             respBusErr,
  output logic [VA_W-1:0]  respAddr
);

  localparam int NXT_LO = TAG_W + 1;
  localparam int PRM_LO = NXT_LO + IDX_W;
  localparam int RLC_LO = PRM_LO + 3;

  // key formation and split
  logic [KEY_W-1:0] key;
  logic [IDX_W-1:0] idxBase, idxAlt, idxNew;
  logic [TAG_W-1:0] tagBase, tagAlt, tagNew;

  assign key     = {(reqSuper ? asiSuper : asiUser), reqAddr[VA_W-1:OFF_W]};
  assign idxBase = key[IDX_W-1:0];
  assign tagBase = key[KEY_W-1:IDX_W];

  generate
    if (ALT_SHIFT == 0) begin : gNoAlt
      assign idxAlt = idxBase;
      assign tagAlt = tagBase;
    end else begin : gAlt
      assign idxAlt = key[IDX_W+ALT_SHIFT-1:ALT_SHIFT];
      assign tagAlt = {key[KEY_W-1:IDX_W+ALT_SHIFT], key[ALT_SHIFT-1:0]};
    end
  endgenerate

  assign idxNew = splitSel ? idxAlt : idxBase;
  assign tagNew = splitSel ? tagAlt : tagBase;

  // captured request
  logic [IDX_W-1:0] curIdx;
  logic [TAG_W-1:0] reqTag;
  logic [OFF_W-1:0] reqOff;
  logic             curWrite, curSuper;

  // relocation table and usage bits
  logic [ENT_W-1:0] tbl [DEPTH];
  logic [DEPTH-1:0] usageBits;

  always_ff @(posedge clk) begin
    if (tblWe) tbl[tblAddr] <= tblWrData;
  end

  assign tblRdData  = tbl[tblAddr];
  assign usageRdBit = usageBits[tblAddr];

  // probe evaluation
  logic [ENT_W-1:0] curEnt;
  logic             eHdr, eRead, eWrite, eUser;
  logic [TAG_W-1:0] eTag;
  logic [IDX_W-1:0] eNext;
  logic [VPN_W-1:0] eReloc;
  logic             tagMatch, permOk, headerOk;

  assign curEnt = tbl[curIdx];
  assign eHdr   = curEnt[0];
  assign eTag   = curEnt[TAG_W:1];
  assign eNext  = curEnt[PRM_LO-1:NXT_LO];
  assign eRead  = curEnt[PRM_LO];
  assign eWrite = curEnt[PRM_LO+1];
  assign eUser  = curEnt[PRM_LO+2];
  assign eReloc = curEnt[ENT_W-1:RLC_LO];

  assign tagMatch     = (eTag == reqTag);
  assign permOk       = (curWrite ? eWrite : eRead) && (curSuper || eUser);
  assign headerOk     = strobe.firstProbe ? eHdr : !eHdr;
  assign probeHit     = tagMatch && headerOk && permOk;
  assign probeRuleErr = !headerOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx   <= '0;
      reqTag   <= '0;
      reqOff   <= '0;
      curWrite <= 1'b0;
      curSuper <= 1'b0;
    end else if (strobe.loadReq) begin
      curIdx   <= idxNew;
      reqTag   <= tagNew;
      reqOff   <= reqAddr[OFF_W-1:0];
      curWrite <= reqWrite;
      curSuper <= reqSuper;
    end else if (strobe.advance) begin
      curIdx <= eNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usageBits <= '0;
    end else begin
      if (usageWe)          usageBits[tblAddr] <= usageWrBit;
      if (strobe.finishHit) usageBits[curIdx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respBusErr <= 1'b0;
      respAddr   <= '0;
    end else begin
      respValid  <= strobe.finishHit || strobe.finishErr || strobe.finishBypass;
      respBusErr <= strobe.finishErr;
      if (strobe.finishBypass)   respAddr <= reqAddr;
      else if (strobe.finishHit) respAddr <= {eReloc, reqOff};
      else if (strobe.finishErr) respAddr <= '0;
    end
  end

endmodule

// File: rtl/hash_walker.sv
`timescale 1ns/1ps
module hash_walker
  import walker_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int VPN_W      = 22,
  parameter int ASI_W      = 8,
  parameter int IDX_W      = 6,
  parameter int ALT_SHIFT  = 3,
  parameter int MAX_PROBES = 16384,
  localparam int ENT_W     = VPN_W + 3 + IDX_W + (ASI_W + VPN_W - IDX_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic             reqWrite,
  input  logic             reqSuper,
  input  logic             bypass,
  input  logic             splitSel,
  input  logic [ASI_W-1:0] asiUser,
  input  logic [ASI_W-1:0] asiSuper,
  output logic             respValid,
  output logic             respBusErr,
  output logic [VA_W-1:0]  respAddr,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic             tblWe,
  input  logic [ENT_W-1:0] tblWrData,
  output logic [ENT_W-1:0] tblRdData,
  input  logic             usageWe,
  input  logic             usageWrBit,
  output logic             usageRdBit
);

  walkStrobe_t strobe;
  logic        probeHit, probeRuleErr;

  walker_ctrl #(.MAX_PROBES(MAX_PROBES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .bypass(bypass),
    .probeHit(probeHit), .probeRuleErr(probeRuleErr),
    .reqReady(reqReady), .strobe(strobe)
  );

  walker_dp #(
    .VA_W(VA_W), .VPN_W(VPN_W), .ASI_W(ASI_W), .IDX_W(IDX_W), .ALT_SHIFT(ALT_SHIFT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSuper(reqSuper),
    .splitSel(splitSel), .asiUser(asiUser), .asiSuper(asiSuper),
    .tblAddr(tblAddr), .tblWe(tblWe), .tblWrData(tblWrData), .tblRdData(tblRdData),
    .usageWe(usageWe), .usageWrBit(usageWrBit), .usageRdBit(usageRdBit),
    .probeHit(probeHit), .probeRuleErr(probeRuleErr),
    .respValid(respValid), .respBusErr(respBusErr), .respAddr(respAddr)
  );

endmodule

// File: rtl/walker_chk.sv
`timescale 1ns/1ps
module walker_chk #(
  parameter int VA_W       = 32,
  parameter int MAX_PROBES = 16384,
  localparam int CNT_W     = $clog2(MAX_PROBES + 2)
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            bypass,
  input logic [VA_W-1:0] reqAddr,
  input logic            respValid,
  input logic            respBusErr,
  input logic [VA_W-1:0] respAddr
);

  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyCnt <= '0;
    else if (reqReady) busyCnt <= '0;
    else               busyCnt <= busyCnt + 1'b1;
  end

  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> reqReady); // R11

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !bypass) |=> !reqReady); // R11

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && bypass) |=> (respValid && !respBusErr && respAddr == $past(reqAddr))); // R10

  AST_WALK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> respValid); // R6

  AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(MAX_PROBES)); // R8

endmodule

bind hash_walker walker_chk #(.VA_W(VA_W), .MAX_PROBES(MAX_PROBES)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .bypass(bypass), .reqAddr(reqAddr), .respValid(respValid),
  .respBusErr(respBusErr), .respAddr(respAddr)
);

// File: tb/tb_hash_walker.sv
`timescale 1ns/1ps
module tb_hash_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqSuper, bypass, splitSel;
  logic [31:0] reqAddr;
  logic [7:0]  asiUser, asiSuper;
  logic        reqReady, respValid, respBusErr;
  logic [31:0] respAddr;
  logic [5:0]  tblAddr;
  logic        tblWe, usageWe, usageWrBit, usageRdBit;
  logic [55:0] tblWrData, tblRdData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hash_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSuper(reqSuper), .bypass(bypass),
    .splitSel(splitSel), .asiUser(asiUser), .asiSuper(asiSuper),
    .respValid(respValid), .respBusErr(respBusErr), .respAddr(respAddr),
    .tblAddr(tblAddr), .tblWe(tblWe), .tblWrData(tblWrData), .tblRdData(tblRdData),
    .usageWe(usageWe), .usageWrBit(usageWrBit), .usageRdBit(usageRdBit)
  );

  typedef struct packed {
    logic        sup;
    logic        wr;
    logic        sp;
    logic        byp;
    logic [31:0] va;
    logic        err;
    logic [21:0] reloc;
    logic [15:0] cyc;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_1455, 1'b0, 22'h00ABCD, 16'd2}, // R6 second entry
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_1455, 1'b0, 22'h00BEEF, 16'd3}, // R5 skip read-only
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_1455, 1'b1, 22'h000000, 16'd4}, // R7 wrap
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h5678_1C2A, 1'b0, 22'h012345, 16'd1}, // R4 first probe
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_2401, 1'b0, 22'h007070, 16'd1}, // R5 supervisor
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_7800, 1'b1, 22'h000000, 16'd1}, // R7 no header
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 22'h000000, 16'd0}, // R10 bypass
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'h0001_6000, 1'b0, 22'h03C3C3, 16'd1}, // R2 alt split
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_6000, 1'b0, 22'h02D2D2, 16'd1}, // R2 base split
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'h5678_1C00, 1'b0, 22'h012345, 16'd1}  // R4 write hit
  };

  function automatic logic [29:0] keyOf(logic [7:0] asi, logic [31:0] va);
    return {asi, va[31:10]};
  endfunction

  function automatic logic [5:0] idxOf(logic [7:0] asi, logic [31:0] va, logic sp);
    logic [29:0] k = keyOf(asi, va);
    return sp ? k[8:3] : k[5:0];
  endfunction

  function automatic logic [23:0] tagOf(logic [7:0] asi, logic [31:0] va, logic sp);
    logic [29:0] k = keyOf(asi, va);
    return sp ? {k[29:9], k[2:0]} : k[29:6];
  endfunction

  function automatic logic [55:0] packEnt(logic [21:0] reloc, logic [2:0] perm,
                                          logic [5:0] nxt, logic [23:0] tag, logic hdr);
    return {reloc, perm, nxt, tag, hdr};
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic writeEnt(logic [5:0] idx, logic [55:0] ent);
    @(negedge clk);
    tblAddr = idx; tblWrData = ent; tblWe = 1'b1;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic writeUsage(logic [5:0] idx, logic bitVal);
    @(negedge clk);
    tblAddr = idx; usageWrBit = bitVal; usageWe = 1'b1;
    @(negedge clk);
    usageWe = 1'b0;
  endtask

  task automatic readUsage(logic [5:0] idx, output logic val);
    @(negedge clk);
    tblAddr = idx;
    #1 val = usageRdBit;
  endtask

  task automatic runReq(input logic sup, input logic wr, input logic sp, input logic byp,
                        input logic [31:0] va, input bit noise,
                        output logic err, output logic [31:0] addr, output int cyc);
    @(negedge clk);
    reqValid = 1'b1; reqSuper = sup; reqWrite = wr; splitSel = sp;
    bypass = byp; reqAddr = va;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; bypass = 1'b0;
    cyc = 0;
    while (!respValid && cyc < 20000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (noise && cyc == 2) begin
        check("R11 ready low while walking", 64'(reqReady), 64'd0);
        reqValid = 1'b1; bypass = 1'b1; reqAddr = 32'hCAFE_0000;
      end
      if (noise && cyc == 4) begin
        reqValid = 1'b0; bypass = 1'b0;
      end
    end
    err  = respBusErr;
    addr = respAddr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        err, ub;
    logic [31:0] addr;
    int          cyc;
    logic [23:0] uTag;

    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqSuper = 1'b0;
    bypass = 1'b0; splitSel = 1'b0; reqAddr = '0;
    asiUser = 8'h11; asiSuper = 8'h22;
    tblAddr = '0; tblWe = 1'b0; tblWrData = '0; usageWe = 1'b0; usageWrBit = 1'b0;

    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(reqReady), 64'd1);
    check("R1 no response in reset", 64'(respValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(reqReady), 64'd1);
    check("R1 no response after reset", 64'(respValid), 64'd0);

    for (int i = 0; i < 64; i++) writeUsage(6'(i), 1'b0);

    uTag = tagOf(8'h11, 32'h1234_1455, 1'b0);
    writeEnt(6'd5,  packEnt(22'h001111, 3'b111, 6'd20, 24'h999999, 1'b1));
    writeEnt(6'd20, packEnt(22'h00ABCD, 3'b101, 6'd21, uTag, 1'b0));
    writeEnt(6'd21, packEnt(22'h00BEEF, 3'b111, 6'd5,  uTag, 1'b0));
    writeEnt(idxOf(8'h11, 32'h5678_1C2A, 1'b0),
             packEnt(22'h012345, 3'b111, 6'd7, tagOf(8'h11, 32'h5678_1C2A, 1'b0), 1'b1));
    writeEnt(idxOf(8'h22, 32'h0000_2401, 1'b0),
             packEnt(22'h007070, 3'b011, 6'd9, tagOf(8'h22, 32'h0000_2401, 1'b0), 1'b1));
    writeEnt(6'd30, packEnt(22'h0F0F0F, 3'b111, 6'd30, 24'h000000, 1'b0));
    writeEnt(idxOf(8'h11, 32'h0001_6000, 1'b1),
             packEnt(22'h03C3C3, 3'b111, 6'd11, tagOf(8'h11, 32'h0001_6000, 1'b1), 1'b1));
    writeEnt(idxOf(8'h11, 32'h0001_6000, 1'b0),
             packEnt(22'h02D2D2, 3'b111, 6'd24, tagOf(8'h11, 32'h0001_6000, 1'b0), 1'b1));
    writeEnt(6'd40, packEnt(22'h000001, 3'b111, 6'd41, 24'hFFFFFF, 1'b1));
    writeEnt(6'd41, packEnt(22'h000002, 3'b111, 6'd42, 24'hFFFFFF, 1'b0));
    writeEnt(6'd42, packEnt(22'h000003, 3'b111, 6'd41, 24'hFFFFFF, 1'b0));

    // R12 / R3: entry read back with its field layout
    @(negedge clk);
    tblAddr = 6'd20;
    #1 check("R12 entry readback", 64'(tblRdData),
             64'(packEnt(22'h00ABCD, 3'b101, 6'd21, uTag, 1'b0)));
    check("R3 next field bits 30:25", 64'(tblRdData[30:25]), 64'd21);

    for (int v = 0; v < NVEC; v++) begin
      runReq(VECS[v].sup, VECS[v].wr, VECS[v].sp, VECS[v].byp, VECS[v].va, 1'b0,
             err, addr, cyc);
      check($sformatf("R7 vector %0d bus error", v), 64'(err), 64'(VECS[v].err));
      if (!VECS[v].err)
        check($sformatf("R4 vector %0d address", v), 64'(addr),
              VECS[v].byp ? 64'(VECS[v].va) : 64'({VECS[v].reloc, VECS[v].va[9:0]}));
      check($sformatf("R6 vector %0d latency", v), 64'(cyc), 64'(VECS[v].cyc));
      @(negedge clk);
      check($sformatf("R4 vector %0d single pulse", v), 64'(respValid), 64'd0);
    end

    // R9: usage bits after the vectors
    readUsage(6'd20, ub); check("R9 usage set on hit idx20", 64'(ub), 64'd1);
    readUsage(6'd21, ub); check("R9 usage set on hit idx21", 64'(ub), 64'd1);
    readUsage(6'd5,  ub); check("R9 usage clear on probed idx5", 64'(ub), 64'd0);
    readUsage(6'd30, ub); check("R9 usage clear after bus error", 64'(ub), 64'd0);
    readUsage(idxOf(8'h11, 32'hDEAD_BEEF, 1'b0), ub);
    check("R9 usage clear after bypass", 64'(ub), 64'd0);
    readUsage(6'd11, ub); check("R9 usage set alt split", 64'(ub), 64'd1);
    writeUsage(6'd20, 1'b0);
    readUsage(6'd20, ub); check("R9 usage cleared by CPU", 64'(ub), 64'd0);

    // R5: user bit clear denies a user access that matches the tag
    asiUser = 8'h22;
    runReq(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2401, 1'b0, err, addr, cyc);
    check("R5 user denied gives bus error", 64'(err), 64'd1);
    check("R5 user denied probe count", 64'(cyc), 64'd2);
    asiUser = 8'h11;

    // R8 / R11: cyclic chain without header, noise during the walk
    runReq(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_A000, 1'b1, err, addr, cyc);
    check("R8 probe cap bus error", 64'(err), 64'd1);
    check("R8 probe cap cycle count", 64'(cyc), 64'd16384);
    @(negedge clk);
    check("R11 ignored request gave no response", 64'(respValid), 64'd0);
    readUsage(6'd47, ub);
    check("R11 ignored request touched no usage", 64'(ub), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule